// File: doc/BRIEF.md
# Fast Page Mode DRAM Read Sequencer

This block turns single byte-read requests into the row-strobe, column-strobe and multiplexed-address waveforms that a fast page mode DRAM expects. It then hands back the addressed byte together with a one-cycle internal transfer acknowledge. After every access the row is left open. A later request to the same row skips activation and goes straight to the column phase. A request to any other row first closes the page, waits out the row precharge count and then opens the new row. A separate close command shuts the page, either at once when the sequencer is idle or at the end of the transfer in flight.

A request is a one-cycle strobe with a byte address laid out as `{row, column, lane}`. It is taken only while the sequencer is idle. The two lane bits pick one column strobe and one byte of the 32-bit data word. The byte is sampled on the clock edge that ends the acknowledge cycle. All timing is counted in whole clocks of a single rising-edge clock. The column strobe falls one clock after the column address is first driven, so the address is stable for a full cycle before the strobe edge.

Top module: `fpm_rd_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it: `ras_n` is 1, `cas_n` is all ones and `xfer_ack` is 0. No row counts as open, so the first access takes the closed-page timing.
- R2: Row activation. `ras_n` is high for at least `RP_CYCLES` cycles before it falls, and `dram_addr` carries the requested row in the cycle `ras_n` first reads 0. From a closed page whose precharge has expired, `xfer_ack` is seen 5 clock edges after the edge that samples the request. From an open page to a different row, it is seen `RP_CYCLES`+5 edges after.
- R3: In the cycle after `ras_n` falls, `dram_addr` switches to the column. The column is on `dram_addr` in the cycle before a column strobe falls and stays there while the strobe is low.
- R4: `xfer_ack` is high for exactly one cycle. The column strobe is low in that cycle and in the cycle before it. Strobe and acknowledge return high together on the next edge.
- R5: `rd_data` takes the addressed byte of `dram_dq` on the edge that ends the acknowledge cycle and holds it afterwards. Lane k maps to `dram_dq[31-8k -: 8]`, so lane 0 is the most significant byte.
- R6: Without a close command, `ras_n` stays low after the transfer completes.
- R7: A request to the open row keeps `ras_n` low throughout the access. With g idle cycles before the request cycle (counted from the first idle cycle after the previous acknowledge), `xfer_ack` is seen max(`CP_CYCLES`-g-1,0)+3 edges after the sampling edge.
- R8: Every column strobe has been high for at least `CP_CYCLES` cycles before it falls.
- R9: `req_addr` is `{row[ROW_W-1:0], col[COL_W-1:0], lane[1:0]}`. Only `cas_n[lane]` goes low during a transfer, and at most one bit of `cas_n` is ever low.
- R10: A `page_close` pulse while idle with a page open drives `ras_n` high from the next cycle. The next request, even to the same row, takes the closed-page timing.
- R11: A `page_close` pulse during a transfer does not change that transfer's timing or data. `ras_n` is high in the cycle after its acknowledge.
- R12: A request strobe while a transfer is in progress is ignored. It produces no further acknowledge, and the open row and latched address do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle read request strobe, taken when idle |
| req_addr | input | ROW_W+COL_W+2 | Byte address `{row, col, lane}` |
| page_close | input | 1 | Close the open page (deferred to end of transfer when busy) |
| dram_dq | input | 32 | Data word from the DRAM |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 4 | Active-low column strobe per byte lane |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| xfer_ack | output | 1 | Internal transfer acknowledge, one cycle |
| rd_data | output | 8 | Sampled read byte |

## Verification
The assertions check these properties on every cycle:
- the row and column strobe precharge minimums;
- the row address at the falling edge of the row strobe;
- column address stability around the falling edge of the column strobe;
- the one-cycle acknowledge with its column strobe;
- one-hot lanes;
- the row strobe held low after a page hit;
- requests ignored while busy.

Some behaviour only the bench scenarios can show: the exact hit and miss latencies as a function of idle gap, and which data byte each lane returns. The bench also covers the closed-page timing after an idle close or a close during a transfer, and the fact that a stray request during a transfer changes nothing.

// File: rtl/fpm_seq_pkg.sv
package fpm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_ACK
    } seq_state_e;

    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 1) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic int unsigned lane_bits(input int unsigned lanes);
        return (lanes < 2) ? 1 : $clog2(lanes);
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_prech_timer.sv
module fpm_prech_timer
    import fpm_seq_pkg::*;
#(
    parameter int unsigned CYCLES = 3,
    localparam int unsigned CW = cnt_width(CYCLES)
)(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired_o = (cnt == '0);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (!expired_o || CYCLES == 0)); // R8

endmodule

// File: rtl/fpm_page_track.sv
module fpm_page_track #(
    parameter int unsigned ROW_W = 10
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] cmp_row_i,
    output logic             valid_o,
    output logic             hit_o
);

    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            open_row <= '0;
        end else if (close_i) begin
            valid_o <= 1'b0;
        end else if (open_i) begin
            valid_o  <= 1'b1;
            open_row <= open_row_i;
        end
    end

    assign hit_o = valid_o && (open_row == cmp_row_i);

    AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(open_i && close_i)); // R10

    AST_OPEN_ONLY_CLOSED: assert property (@(posedge clk) disable iff (rst)
        open_i |-> !valid_o); // R2

endmodule

// File: rtl/fpm_lane_mux.sv
module fpm_lane_mux
    import fpm_seq_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned LANE_W = lane_bits(LANES),
    localparam int unsigned DQ_W = LANES * 8
)(
    input  logic [LANE_W-1:0] lane_i,
    input  logic              active_i,
    input  logic [DQ_W-1:0]   dq_i,
    output logic [LANES-1:0]  cas_n_o,
    output logic [7:0]        byte_o
);

    logic [7:0] lane_bytes [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_bytes[k] = dq_i[DQ_W-1-8*k -: 8];
        assign cas_n_o[k]    = !(active_i && (lane_i == LANE_W'(k)));
    end

    assign byte_o = lane_bytes[lane_i];

endmodule

// File: rtl/fpm_rd_seq.sv
module fpm_rd_seq
    import fpm_seq_pkg::*;
#(
    parameter int unsigned ROW_W     = 10,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned LANES     = 4,
    parameter int unsigned RP_CYCLES = 3,
    parameter int unsigned CP_CYCLES = 2,
    localparam int unsigned LANE_W = lane_bits(LANES),
    localparam int unsigned ADDR_W = max_of(ROW_W, COL_W),
    localparam int unsigned DQ_W   = LANES * 8,
    localparam int unsigned REQ_W  = ROW_W + COL_W + LANE_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic              page_close,
    input  logic [DQ_W-1:0]   dram_dq,
    output logic              ras_n,
    output logic [LANES-1:0]  cas_n,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              xfer_ack,
    output logic [7:0]        rd_data
);

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LANE_W-1:0] lane;
    } req_t;

    localparam int unsigned RW = cnt_width(RP_CYCLES);
    localparam int unsigned CWH = cnt_width(CP_CYCLES);

    seq_state_e state, state_nx;
    req_t       in_req, req_q;
    logic       close_pend, close_now;
    logic       page_valid, row_hit;
    logic       rp_expired, cp_expired;
    logic       open_ev, close_ev, cas_load;
    logic       cas_active;
    logic [7:0] lane_byte;

    assign in_req    = req_t'(req_addr);
    assign close_now = page_close || close_pend;

    // page bookkeeping events
    assign open_ev  = (state == ST_PRE) && rp_expired;
    assign close_ev = ((state == ST_IDLE) && page_valid &&
                       (close_now || (req_valid && !row_hit)))
                   || ((state == ST_ACK) && close_now);
    assign cas_load = (state == ST_ACK);

    fpm_page_track #(.ROW_W(ROW_W)) u_page (
        .clk        (clk),
        .rst        (rst),
        .open_i     (open_ev),
        .open_row_i (req_q.row),
        .close_i    (close_ev),
        .cmp_row_i  (in_req.row),
        .valid_o    (page_valid),
        .hit_o      (row_hit)
    );

    fpm_prech_timer #(.CYCLES(RP_CYCLES)) u_rp_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (close_ev),
        .expired_o (rp_expired)
    );

    fpm_prech_timer #(.CYCLES(CP_CYCLES)) u_cp_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (cas_load),
        .expired_o (cp_expired)
    );

    // sequencing
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = (row_hit && !close_now) ? ST_COL : ST_PRE;
            ST_PRE:  if (rp_expired) state_nx = ST_ROW;
            ST_ROW:  state_nx = ST_COL;
            ST_COL:  if (cp_expired) state_nx = ST_CAS;
            ST_CAS:  state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req_q      <= '0;
            close_pend <= 1'b0;
            rd_data    <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                req_q <= in_req;
            end
            if (state == ST_IDLE || state == ST_ACK) begin
                close_pend <= 1'b0;
            end else if (page_close) begin
                close_pend <= 1'b1;
            end
            if (state == ST_ACK) begin
                rd_data <= lane_byte;
            end
        end
    end

    // pin drive
    assign cas_active = (state == ST_CAS) || (state == ST_ACK);
    assign xfer_ack   = (state == ST_ACK);
    assign ras_n      = !page_valid;

    always_comb begin
        if (state == ST_COL || state == ST_CAS || state == ST_ACK) begin
            dram_addr = ADDR_W'(req_q.col);
        end else begin
            dram_addr = ADDR_W'(req_q.row);
        end
    end

    fpm_lane_mux #(.LANES(LANES)) u_lane (
        .lane_i   (req_q.lane),
        .active_i (cas_active),
        .dq_i     (dram_dq),
        .cas_n_o  (cas_n),
        .byte_o   (lane_byte)
    );

    // strobe high-time counters used by the precharge checks
    logic [RW-1:0]  ras_hi_cnt;
    logic [CWH-1:0] cas_hi_cnt;
    logic           any_cas_low;

    assign any_cas_low = (cas_n != '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_hi_cnt <= RW'(RP_CYCLES);
            cas_hi_cnt <= CWH'(CP_CYCLES);
        end else begin
            if (!ras_n) ras_hi_cnt <= '0;
            else if (ras_hi_cnt < RW'(RP_CYCLES)) ras_hi_cnt <= ras_hi_cnt + RW'(1);
            if (any_cas_low) cas_hi_cnt <= '0;
            else if (cas_hi_cnt < CWH'(CP_CYCLES)) cas_hi_cnt <= cas_hi_cnt + CWH'(1);
        end
    end

    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (ras_hi_cnt >= RW'(RP_CYCLES))); // R2

    AST_ROW_ON_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (dram_addr == ADDR_W'(req_q.row))); // R2

    AST_COL_AFTER_ROW: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |=> (dram_addr == ADDR_W'(req_q.col))); // R3

    AST_COL_STABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(any_cas_low) |-> $stable(dram_addr)); // R3

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |=> !xfer_ack); // R4

    AST_ACK_WITH_CAS: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> (any_cas_low && $past(any_cas_low))); // R4

    AST_CAS_ENDS_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_ack) |-> !any_cas_low); // R4

    AST_RAS_HELD: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && !close_now) |=> !ras_n); // R6

    AST_HIT_NO_RAS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && row_hit && !close_now) |=> (!ras_n && state == ST_COL)); // R7

    AST_CAS_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        $rose(any_cas_low) |-> (cas_hi_cnt >= CWH'(CP_CYCLES))); // R8

    AST_CAS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cas_n)); // R9

    AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
        any_cas_low |-> !ras_n); // R9

    AST_CLOSE_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && close_now) |=> ras_n); // R11

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(req_q)); // R12

endmodule

// File: tb/fpm_rd_seq_tb.sv
module fpm_rd_seq_tb;

    localparam int ROW_W = 10;
    localparam int COL_W = 10;
    localparam int LANES = 4;
    localparam int RP    = 3;
    localparam int CP    = 2;
    localparam int REQ_W = ROW_W + COL_W + 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [REQ_W-1:0]  req_addr;
    logic              page_close;
    logic [31:0]       dram_dq;
    logic              ras_n;
    logic [3:0]        cas_n;
    logic [9:0]        dram_addr;
    logic              xfer_ack;
    logic [7:0]        rd_data;

    always #5 clk = ~clk;

    fpm_rd_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES),
        .RP_CYCLES(RP), .CP_CYCLES(CP)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .page_close(page_close), .dram_dq(dram_dq), .ras_n(ras_n),
        .cas_n(cas_n), .dram_addr(dram_addr), .xfer_ack(xfer_ack),
        .rd_data(rd_data)
    );

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    int  idle_cyc = 100;
    bit  b_open = 1'b0;
    bit  after_close = 1'b0;
    logic [9:0] b_row = '0;
    logic [9:0] cur_row = '0;
    logic [9:0] cur_col = '0;

    function automatic logic [31:0] word_of(input logic [9:0] r, input logic [9:0] c);
        return {r[7:0] ^ c[7:0], c[7:0] + 8'h3C, r[7:0] + c[7:0] + 8'h11, ~c[7:0]};
    endfunction

    function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] lane);
        return w[8*(3-int'(lane)) +: 8];
    endfunction

    function automatic int hit_latency(input int gap);
        int w;
        w = CP - gap - 1;
        return ((w > 0) ? w : 0) + 3;
    endfunction

    assign dram_dq = (cas_n != 4'hF) ? word_of(cur_row, cur_col) : 32'hA5C3_5A3C;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic idle_tick();
        @(negedge clk);
        idle_cyc++;
    endtask

    task automatic do_read(input logic [9:0] row, input logic [9:0] col, input logic [1:0] lane,
                           input int gap, input bit close_mid, input bit extra_req);
        bit hit, got, ras_fell_prev, p_ras;
        logic [3:0] p_cas;
        logic [9:0] p_addr;
        int lat_exp;
        string ltag;
        repeat (gap) idle_tick();
        hit = b_open && (row == b_row);
        if (hit) begin
            lat_exp = hit_latency(idle_cyc);
            ltag = "R7 hit latency";
        end else if (b_open) begin
            lat_exp = RP + 5;
            ltag = "R2 open-miss latency";
        end else begin
            lat_exp = 5;
            ltag = after_close ? "R10 closed-page latency" : "R2 closed-page latency";
        end
        cur_row = row;
        cur_col = col;
        req_addr  = {row, col, lane};
        req_valid = 1'b1;
        p_ras  = ras_n;
        p_cas  = cas_n;
        p_addr = dram_addr;
        ras_fell_prev = 1'b0;
        got = 1'b0;
        for (int n = 1; n <= 40 && !got; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req_valid = 1'b0;
                if (extra_req) begin
                    req_valid = 1'b1;
                    req_addr  = {~row, ~col, lane + 2'd1};
                end
                if (close_mid) page_close = 1'b1;
            end else if (n == 2) begin
                req_valid  = 1'b0;
                page_close = 1'b0;
            end
            if (ras_fell_prev) chk(dram_addr == col, "R3 column after row", dram_addr, col);
            ras_fell_prev = 1'b0;
            if (p_ras && !ras_n) begin
                chk(dram_addr == row, "R2 row on RAS fall", dram_addr, row);
                ras_fell_prev = 1'b1;
            end
            if (p_cas == 4'hF && cas_n != 4'hF) begin
                chk(p_addr == col && dram_addr == col, "R3 column stable at CAS", dram_addr, col);
                chk(cas_n == ~(4'b0001 << lane), "R9 lane strobe", cas_n, ~(4'b0001 << lane));
            end
            if (hit) chk(!ras_n, "R7 RAS held on hit", ras_n, 0);
            if (xfer_ack) begin
                got = 1'b1;
                chk(n == lat_exp, ltag, n, lat_exp);
                chk(cas_n == ~(4'b0001 << lane), "R4 CAS low with ack", cas_n, ~(4'b0001 << lane));
            end
            p_ras  = ras_n;
            p_cas  = cas_n;
            p_addr = dram_addr;
        end
        if (!got) chk(1'b0, "R4 ack missing", 0, 1);
        @(negedge clk);
        idle_cyc = 0;
        chk(!xfer_ack && cas_n == 4'hF, "R4 ack and CAS end together", {xfer_ack, cas_n}, 5'h0F);
        chk(rd_data == byte_of(word_of(row, col), lane), "R5 read byte", rd_data,
            byte_of(word_of(row, col), lane));
        if (close_mid) chk(ras_n == 1'b1, "R11 RAS high after closing transfer", ras_n, 1);
        else           chk(ras_n == 1'b0, "R6 page stays open", ras_n, 0);
        b_open = !close_mid;
        b_row  = row;
        after_close = close_mid;
        if (close_mid) repeat (RP + 1) idle_tick();
        if (extra_req) begin
            for (int k = 0; k < 3; k++) begin
                idle_tick();
                chk(!xfer_ack && !ras_n && cas_n == 4'hF, "R12 stray request ignored",
                    {xfer_ack, ras_n, cas_n}, 6'h0F);
            end
        end
    endtask

    task automatic close_idle();
        if (b_open) chk(ras_n == 1'b0, "R10 page open before close", ras_n, 0);
        page_close = 1'b1;
        idle_tick();
        page_close = 1'b0;
        chk(ras_n == 1'b1, "R10 idle close", ras_n, 1);
        repeat (RP + 1) idle_tick();
        b_open = 1'b0;
        after_close = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            fails++;
            $display("FAIL R4 watchdog expired act=%0d exp=done", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        page_close = 1'b0;
        repeat (4) @(negedge clk);
        chk(ras_n && cas_n == 4'hF && !xfer_ack, "R1 reset outputs", {ras_n, cas_n, xfer_ack}, 6'h3E);
        rst = 1'b0;
        @(negedge clk);
        chk(ras_n && cas_n == 4'hF && !xfer_ack, "R1 after reset", {ras_n, cas_n, xfer_ack}, 6'h3E);

        // directed corners
        do_read(10'd5, 10'd9,  2'd0, 0, 1'b0, 1'b0);  // R1 first access is closed-page
        do_read(10'd5, 10'd10, 2'd1, 0, 1'b0, 1'b0);  // R7 gap 0
        do_read(10'd5, 10'd11, 2'd2, 1, 1'b0, 1'b0);  // R7 gap 1
        do_read(10'd5, 10'd12, 2'd3, 3, 1'b0, 1'b0);  // R7 long gap, R5 lane 3
        do_read(10'd6, 10'd1,  2'd0, 0, 1'b0, 1'b0);  // R2 open miss
        do_read(10'd6, 10'd2,  2'd1, 0, 1'b0, 1'b1);  // R12
        do_read(10'd6, 10'd3,  2'd2, 0, 1'b1, 1'b0);  // R11
        do_read(10'd6, 10'd4,  2'd3, 0, 1'b0, 1'b0);  // R10 same row after close
        close_idle();                                  // R10
        do_read(10'd6, 10'd5,  2'd0, 0, 1'b0, 1'b0);

        // constrained random mix
        for (int i = 0; i < 80; i++) begin
            logic [9:0] r;
            logic [9:0] c;
            logic [1:0] ln;
            int g;
            int pick;
            pick = int'($urandom_range(0, 9));
            r  = (pick < 5) ? b_row : 10'($urandom_range(0, 1023));
            c  = 10'($urandom_range(0, 1023));
            ln = 2'($urandom_range(0, 3));
            g  = int'($urandom_range(0, 3));
            if (pick == 9 && b_open) close_idle();
            do_read(r, c, ln, g, (pick == 8), (pick == 7));
        end

        summary();
        $finish;
    end

endmodule